// File: doc/BRIEF.md
# Dual-Lane Compare and Condition Unit

This block keeps the two condition flags of a shader core and turns them into branch decisions. A compare instruction presents four 24-bit sign-magnitude floating-point operands: a pair for the x lane and a pair for the y lane. Each lane carries its own comparison operator, and the two results are written to the x flag and the y flag on the same clock edge.

Flow-control instructions query the flags. A query supplies a reference bit for each lane and a combine selector. Each flag is tested for equality with its reference bit. The two test results are then merged into a single branch-taken bit by OR, by AND, or by taking only the x test or only the y test. The query path is combinational, so the answer is ready in the same cycle the query is presented.

The compare strobe is a plain single-cycle control input rather than a handshake. The unit accepts a compare on every cycle and never applies back-pressure, so the strobe needs no ready signal. A run-start pulse clears both flags at the start of each program run.

Top module: `cond_unit`

## Requirements
- R1: After reset, and on the clock edge after `run_start` is high, both `flag_x` and `flag_y` read 0.
- R2: On the edge where `cmp_valid` is high, each flag takes the result of its lane's operator applied to (src1, src2). The operator codes are: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal.
- R3: The x-lane operator `cmp_op_x` and the y-lane operator `cmp_op_y` act independently. Each lane's flag depends only on its own operator and its own operands.
- R4: Operands are compared as sign-magnitude numbers, where bit 23 is the sign and bits 22:0 are the magnitude. Among negative values, a larger magnitude is smaller. +0 (0x000000) and -0 (0x800000) compare equal.
- R5: Operator codes 6 and 7 leave the flag of that lane unchanged. When either lane carries such a code on an accepted compare, `cmp_error` is high for exactly the following cycle.
- R6: While `cmp_valid` and `run_start` are both low, both flags hold their value.
- R7: `branch_taken` evaluates tx=(flag_x==ref_x) and ty=(flag_y==ref_y) and then combines them by `combine_sel`: 0 gives tx OR ty, 1 gives tx AND ty, 2 gives tx only, 3 gives ty only.
- R8: `branch_taken` reflects the current flags and query inputs within the same cycle, with no register in the path.
- R9: When `run_start` and `cmp_valid` are high together, the flags clear and the compare is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Clears both flags for a new program run |
| cmp_valid | input | 1 | Compare strobe; the flags load on this edge |
| cmp_op_x | input | 3 | Operator code for the x lane |
| cmp_op_y | input | 3 | Operator code for the y lane |
| src1_x | input | 24 | x-lane first operand |
| src2_x | input | 24 | x-lane second operand |
| src1_y | input | 24 | y-lane first operand |
| src2_y | input | 24 | y-lane second operand |
| ref_x | input | 1 | Reference bit compared against flag_x |
| ref_y | input | 1 | Reference bit compared against flag_y |
| combine_sel | input | 2 | Selects OR, AND, x-only or y-only |
| flag_x | output | 1 | x-lane condition flag |
| flag_y | output | 1 | y-lane condition flag |
| cmp_error | output | 1 | One-cycle pulse for a reserved operator code |
| branch_taken | output | 1 | Combined branch decision |

## Verification
A corrupted flag is visible directly on `flag_x` or `flag_y` half a cycle after the compare edge. It is also visible through `branch_taken` as soon as the bench applies a query that isolates that lane. A flag that fails to hold, or that is overwritten by a reserved code, shows up at the next query after an idle cycle. A stuck or stretched error register shows up as `cmp_error` being wrong in the first or the second cycle after the strobe.

// File: rtl/cond_unit_pkg.sv
package cond_unit_pkg;
  typedef enum logic [2:0] {
    OP_EQ   = 3'd0,
    OP_NE   = 3'd1,
    OP_LT   = 3'd2,
    OP_LE   = 3'd3,
    OP_GT   = 3'd4,
    OP_GE   = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } cmp_op_e;

  typedef enum logic [1:0] {
    MIX_OR  = 2'd0,
    MIX_AND = 2'd1,
    MIX_X   = 2'd2,
    MIX_Y   = 2'd3
  } mix_sel_e;

  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned OP_W      = 3;
endpackage

// File: rtl/sm_order_cmp.sv
module sm_order_cmp #(
  parameter int unsigned VAL_W = 24
) (
  input  logic [VAL_W-1:0] a,
  input  logic [VAL_W-1:0] b,
  output logic             is_eq,
  output logic             is_lt
);
  localparam int unsigned MAG_W = VAL_W - 1;

  logic signed [VAL_W-1:0] key_a, key_b;

  // Map sign-magnitude onto a signed ordinal; both zeros land on 0.
  always_comb begin
    key_a = $signed({1'b0, a[MAG_W-1:0]});
    key_b = $signed({1'b0, b[MAG_W-1:0]});
    if (a[VAL_W-1]) key_a = -key_a;
    if (b[VAL_W-1]) key_b = -key_b;
  end

  assign is_eq = (key_a == key_b);
  assign is_lt = (key_a < key_b);
endmodule

// File: rtl/lane_flag.sv
module lane_flag
  import cond_unit_pkg::*;
#(
  parameter int unsigned VAL_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [OP_W-1:0]  op,
  input  logic [VAL_W-1:0] src1,
  input  logic [VAL_W-1:0] src2,
  output logic             flag,
  output logic             bad_op
);
  logic eq, lt, result;

  sm_order_cmp #(.VAL_W(VAL_W)) cmp_i (
    .a     (src1),
    .b     (src2),
    .is_eq (eq),
    .is_lt (lt)
  );

  always_comb begin
    result = flag;
    bad_op = 1'b0;
    case (cmp_op_e'(op))
      OP_EQ:   result = eq;
      OP_NE:   result = !eq;
      OP_LT:   result = lt;
      OP_LE:   result = lt || eq;
      OP_GT:   result = !(lt || eq);
      OP_GE:   result = !lt;
      default: bad_op = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) flag <= 1'b0;
    else if (load)       flag <= result;
  end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import cond_unit_pkg::*;
(
  input  logic [NUM_LANES-1:0] flags,
  input  logic [NUM_LANES-1:0] refs,
  input  logic [1:0]           sel,
  output logic                 taken
);
  logic [NUM_LANES-1:0] hit;

  assign hit = ~(flags ^ refs);

  always_comb begin
    case (mix_sel_e'(sel))
      MIX_OR:  taken = |hit;
      MIX_AND: taken = &hit;
      MIX_X:   taken = hit[0];
      default: taken = hit[1];
    endcase
  end
endmodule

// File: rtl/cond_unit.sv
module cond_unit
  import cond_unit_pkg::*;
#(
  parameter int unsigned VAL_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic             cmp_valid,
  input  logic [2:0]       cmp_op_x,
  input  logic [2:0]       cmp_op_y,
  input  logic [VAL_W-1:0] src1_x,
  input  logic [VAL_W-1:0] src2_x,
  input  logic [VAL_W-1:0] src1_y,
  input  logic [VAL_W-1:0] src2_y,
  input  logic             ref_x,
  input  logic             ref_y,
  input  logic [1:0]       combine_sel,
  output logic             flag_x,
  output logic             flag_y,
  output logic             cmp_error,
  output logic             branch_taken
);
  logic [NUM_LANES-1:0][OP_W-1:0]  lane_op;
  logic [NUM_LANES-1:0][VAL_W-1:0] lane_a, lane_b;
  logic [NUM_LANES-1:0]            lane_flag_q, lane_bad;

  assign lane_op = {cmp_op_y, cmp_op_x};
  assign lane_a  = {src1_y, src1_x};
  assign lane_b  = {src2_y, src2_x};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_flag #(.VAL_W(VAL_W)) lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (run_start),
      .load   (cmp_valid),
      .op     (lane_op[g]),
      .src1   (lane_a[g]),
      .src2   (lane_b[g]),
      .flag   (lane_flag_q[g]),
      .bad_op (lane_bad[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp_error <= 1'b0;
    else        cmp_error <= cmp_valid && !run_start && (|lane_bad);
  end

  branch_eval eval_i (
    .flags (lane_flag_q),
    .refs  ({ref_y, ref_x}),
    .sel   (combine_sel),
    .taken (branch_taken)
  );

  assign flag_x = lane_flag_q[0];
  assign flag_y = lane_flag_q[1];
endmodule

// File: rtl/cond_unit_chk.sv
module cond_unit_chk #(
  parameter int unsigned VAL_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_start,
  input logic             cmp_valid,
  input logic [2:0]       cmp_op_x,
  input logic [2:0]       cmp_op_y,
  input logic [VAL_W-1:0] src1_x,
  input logic [VAL_W-1:0] src2_x,
  input logic             ref_x,
  input logic             ref_y,
  input logic [1:0]       combine_sel,
  input logic             flag_x,
  input logic             flag_y,
  input logic             cmp_error,
  input logic             branch_taken
);
  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (!flag_x && !flag_y));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !run_start) |=> ($stable(flag_x) && $stable(flag_y)));

  assert_rsv_keep_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !run_start && cmp_op_x[2:1] == 2'b11) |=> ($stable(flag_x) && cmp_error));

  assert_rsv_keep_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !run_start && cmp_op_y[2:1] == 2'b11) |=> ($stable(flag_y) && cmp_error));

  assert_err_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> !cmp_error);

  assert_zero_eq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !run_start && cmp_op_x == 3'd0 &&
     src1_x[VAL_W-2:0] == '0 && src2_x[VAL_W-2:0] == '0) |=> flag_x);

  assert_and_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (combine_sel == 2'd1 && branch_taken) |-> (flag_x == ref_x && flag_y == ref_y));

  assert_xonly_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (combine_sel == 2'd2) |-> (branch_taken == (flag_x == ref_x)));
endmodule

bind cond_unit cond_unit_chk #(.VAL_W(VAL_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_start    (run_start),
  .cmp_valid    (cmp_valid),
  .cmp_op_x     (cmp_op_x),
  .cmp_op_y     (cmp_op_y),
  .src1_x       (src1_x),
  .src2_x       (src2_x),
  .ref_x        (ref_x),
  .ref_y        (ref_y),
  .combine_sel  (combine_sel),
  .flag_x       (flag_x),
  .flag_y       (flag_y),
  .cmp_error    (cmp_error),
  .branch_taken (branch_taken)
);

// File: tb/cond_unit_tb_top.sv
module cond_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_start = 1'b0, cmp_valid = 1'b0;
  logic [2:0]  cmp_op_x = 3'd0, cmp_op_y = 3'd0;
  logic [23:0] src1_x = '0, src2_x = '0, src1_y = '0, src2_y = '0;
  logic        ref_x = 1'b0, ref_y = 1'b0;
  logic [1:0]  combine_sel = 2'd0;
  logic        flag_x, flag_y, cmp_error, branch_taken;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cond_unit dut_i (.*);

  localparam logic [23:0] PZ = 24'h000000, NZ = 24'h800000;
  localparam logic [23:0] PS = 24'h000010, PB = 24'h000200;
  localparam logic [23:0] NS = 24'h800010, NB = 24'h800200;

  function automatic int val_of(logic [23:0] v);
    return v[23] ? -int'(v[22:0]) : int'(v[22:0]);
  endfunction

  function automatic bit model_cmp(logic [2:0] op, logic [23:0] a, logic [23:0] b);
    int x = val_of(a);
    int y = val_of(b);
    case (op)
      3'd0: return x == y;
      3'd1: return x != y;
      3'd2: return x < y;
      3'd3: return x <= y;
      3'd4: return x > y;
      default: return x >= y;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply one compare; on return, the flags and the error bit are half a cycle past the edge.
  task automatic do_cmp(logic [2:0] ox, logic [2:0] oy, logic [23:0] ax, logic [23:0] bx,
                        logic [23:0] ay, logic [23:0] by);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_op_x = ox; cmp_op_y = oy;
    src1_x = ax; src2_x = bx; src1_y = ay; src2_y = by;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic set_flags(bit fx, bit fy);
    do_cmp(fx ? 3'd0 : 3'd1, fy ? 3'd0 : 3'd1, PS, PS, PS, PS);
  endtask

  task automatic t_reset;
    check(flag_x == 0 && flag_y == 0, "R1 reset", {flag_x, flag_y}, 0);
    check(cmp_error == 0, "R1 reset err", cmp_error, 0);
  endtask

  task automatic t_all_ops;
    logic [23:0] vals [6] = '{PZ, PS, PB, NS, NB, NZ};
    for (int op = 0; op < 6; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j += 2) begin
          bit e = model_cmp(3'(op), vals[i], vals[j]);
          do_cmp(3'(op), 3'(op), vals[i], vals[j], vals[j], vals[i]);
          check(flag_x == e, "R2 x op", flag_x, e);
          check(flag_y == model_cmp(3'(op), vals[j], vals[i]), "R2 y op",
                flag_y, model_cmp(3'(op), vals[j], vals[i]));
          check(cmp_error == 0, "R2 no err", cmp_error, 0);
        end
  endtask

  task automatic t_independent;
    do_cmp(3'd2, 3'd4, PS, PB, PS, PB);
    check(flag_x == 1 && flag_y == 0, "R3 lt/gt", {flag_x, flag_y}, 2);
    do_cmp(3'd1, 3'd3, PB, PB, NB, NS);
    check(flag_x == 0 && flag_y == 1, "R3 ne/le", {flag_x, flag_y}, 1);
  endtask

  task automatic t_sign_mag;
    do_cmp(3'd0, 3'd1, PZ, NZ, NZ, PZ);
    check(flag_x == 1 && flag_y == 0, "R4 zeros equal", {flag_x, flag_y}, 2);
    do_cmp(3'd2, 3'd4, NB, NS, NS, PS);
    check(flag_x == 1 && flag_y == 0, "R4 neg order", {flag_x, flag_y}, 2);
  endtask

  task automatic t_reserved;
    set_flags(1, 0);
    do_cmp(3'd6, 3'd0, PS, PB, PS, PS);
    check(flag_x == 1 && flag_y == 1, "R5 x kept", {flag_x, flag_y}, 3);
    check(cmp_error == 1, "R5 pulse", cmp_error, 1);
    @(negedge clk);
    check(cmp_error == 0, "R5 one cycle", cmp_error, 0);
    do_cmp(3'd1, 3'd7, PS, PS, PS, PB);
    check(flag_x == 0 && flag_y == 1, "R5 y kept", {flag_x, flag_y}, 1);
    check(cmp_error == 1, "R5 pulse y", cmp_error, 1);
  endtask

  task automatic t_hold;
    set_flags(1, 0);
    @(negedge clk);
    cmp_op_x = 3'd1; src1_x = PS; src2_x = PS; cmp_op_y = 3'd0;
    repeat (3) @(negedge clk);
    check(flag_x == 1 && flag_y == 0, "R6 hold", {flag_x, flag_y}, 2);
  endtask

  task automatic t_branch;
    for (int f = 0; f < 4; f++) begin
      set_flags(f[0], f[1]);
      for (int r = 0; r < 4; r++)
        for (int m = 0; m < 4; m++) begin
          bit tx = (f[0] == r[0]);
          bit ty = (f[1] == r[1]);
          bit e = (m == 0) ? (tx | ty) : (m == 1) ? (tx & ty) : (m == 2) ? tx : ty;
          ref_x = r[0]; ref_y = r[1]; combine_sel = 2'(m);
          #1;
          check(branch_taken == e, "R7 R8 branch", branch_taken, e);
        end
    end
  endtask

  task automatic t_run_start;
    set_flags(1, 1);
    @(negedge clk);
    run_start = 1'b1; cmp_valid = 1'b1;
    cmp_op_x = 3'd0; cmp_op_y = 3'd0; src1_x = PS; src2_x = PS; src1_y = PS; src2_y = PS;
    @(negedge clk);
    run_start = 1'b0; cmp_valid = 1'b0;
    check(flag_x == 0 && flag_y == 0, "R9 R1 clear wins", {flag_x, flag_y}, 0);
    check(cmp_error == 0, "R9 no err", cmp_error, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_ops();
    t_independent();
    t_sign_mag();
    t_reserved();
    t_hold();
    t_branch();
    t_run_start();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule